// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Controller

This block watches the hot-plug detect pin of a display transmitter. The pin is asynchronous. It passes through a two-flop synchroniser and then a programmable debounce filter. The filter holds a clean connection level. Every change of that filtered level sets a sticky event bit, one bit for connect (rise) and another for disconnect (fall). A level-sensitive interrupt from a neighbouring link controller is captured as a third sticky bit. An enable register gates the three bits, and their OR drives one combined interrupt line.

Software uses a small register port with a one-cycle registered read. Through it, software programs the filter, reads the sticky status and clears it by writing ones. It can also set the interrupt enables and read the present filtered connection level. A typical handler reads the status, writes the same value back to the clear register, and then reads the level register to learn whether a sink is attached.

Top module: `hpd_irq_top`

## Requirements
- R1: After reset, status, enable, filter and level registers all read 0, and `irq_o` and `hpd_level_o` are 0.
- R2: With the filter register at 0, a change on `hpd_i` shows on `hpd_level_o` at the third rising clock edge after the change: two synchroniser stages plus the filter register.
- R3: The filtered level changes only after `thr` consecutive filter samples (filter register bits 7:0) disagree with it. A threshold of 0 acts as 1. Any agreeing sample restarts the count, so shorter pulses are rejected.
- R4: The filter samples once every 2^`psc` clock cycles, where `psc` is filter register bits 15:12.
- R5: A rise of the filtered level sets status bit 1 and a fall sets status bit 2. Each is set even when its enable bit is 0.
- R6: A cycle with `core_irq_i` high sets status bit 0, and the bit stays set after the input drops.
- R7: Writing to the clear register (address 2) clears each status bit whose data bit is 1. Zero bits leave their status bit unchanged. A source that is set in the same cycle as it is cleared stays set. The clear register reads 0.
- R8: The enable register (address 3, bits 2:0, where 1 enables) gates the status bits bit for bit. `irq_o` is high when any enabled status bit is set, and it follows the status by one cycle.
- R9: The level register (address 4) returns the filtered level in bit 0. All other bits read 0.
- R10: The filter register (address 0) stores only bits 15:12 and 7:0. All other bits read 0.
- R11: `rd_valid_o` pulses one cycle after `rd_en_i`, with `rdata_o` valid in that cycle. The status register is at address 1. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_i | input | 1 | Asynchronous hot-plug detect pin |
| core_irq_i | input | 1 | Interrupt level from the neighbouring controller |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Combined interrupt |
| hpd_level_o | output | 1 | Filtered connection level |

## Verification
The embedded assertions check the following on every cycle:
- the filtered level moves only on a sample tick;
- rise and fall events never occur together;
- a sticky bit never drops unless a clear was written;
- every captured event lands in status;
- the interrupt stays low while nothing is enabled.

Only the bench scenarios can show the exact latencies, the rejection of short glitches at a given threshold and prescale, the register layouts, and the rule that set wins over clear.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  localparam int NUM_SRC  = 3;
  localparam int ST_CORE  = 0;
  localparam int ST_RISE  = 1;
  localparam int ST_FALL  = 2;
  localparam int PSC_W    = 4;
  localparam int THR_W    = 8;
  localparam int PSC_LSB  = 12;
  localparam int THR_LSB  = 0;
  localparam int A_FILT   = 0;
  localparam int A_STAT   = 1;
  localparam int A_CLR    = 2;
  localparam int A_EN     = 3;
  localparam int A_LEVEL  = 4;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic [THR_W-1:0] thr;
  } filt_cfg_t;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hpd_debounce.sv
module hpd_debounce
  import hpd_pkg::*;
#(
  parameter int PRE_W = 2**PSC_W
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sample_i,
  input  filt_cfg_t cfg_i,
  output logic      level_o,
  output logic      rise_o,
  output logic      fall_o
);
  localparam int CNT_W = THR_W + 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;
  logic             tick;
  logic [CNT_W-1:0] agree_cnt;
  logic [CNT_W-1:0] thr_eff;
  logic             level_q;

  assign pre_mask = (PRE_W'(1) << cfg_i.psc) - PRE_W'(1);
  assign tick     = ((pre_cnt & pre_mask) == pre_mask);
  assign thr_eff  = (cfg_i.thr == '0) ? CNT_W'(1) : CNT_W'(cfg_i.thr);

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      agree_cnt <= '0;
      level_q   <= 1'b0;
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (tick) begin
        if (sample_i == level_q) begin
          agree_cnt <= '0;
        end else if ((agree_cnt + CNT_W'(1)) >= thr_eff) begin
          agree_cnt <= '0;
          level_q   <= sample_i;
          rise_o    <= sample_i;
          fall_o    <= ~sample_i;
        end else begin
          agree_cnt <= agree_cnt + CNT_W'(1);
        end
      end
    end
  end

  assign level_o = level_q;

  // R4
  level_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> $past(tick));
  // R5
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));
  // R3
  rise_matches_level_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> (level_q && !$past(level_q)));
endmodule

// File: rtl/hpd_regs.sv
module hpd_regs
  import hpd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              core_irq_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              level_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o,
  output logic              irq_o,
  output filt_cfg_t         cfg_o
);
  logic [NUM_SRC-1:0] status_q, en_q, set_vec, clr_vec, status_n;
  filt_cfg_t          cfg_q;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  filt_view;

  assign set_vec[ST_CORE] = core_irq_i;
  assign set_vec[ST_RISE] = rise_i;
  assign set_vec[ST_FALL] = fall_i;

  assign clr_vec  = (wr_en_i && addr_i == ADDR_W'(A_CLR)) ? wdata_i[NUM_SRC-1:0] : '0;
  assign status_n = (status_q & ~clr_vec) | set_vec;

  always_comb begin
    filt_view = '0;
    filt_view[PSC_LSB +: PSC_W] = cfg_q.psc;
    filt_view[THR_LSB +: THR_W] = cfg_q.thr;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(A_FILT):  rd_mux = filt_view;
      ADDR_W'(A_STAT):  rd_mux[NUM_SRC-1:0] = status_q;
      ADDR_W'(A_EN):    rd_mux[NUM_SRC-1:0] = en_q;
      ADDR_W'(A_LEVEL): rd_mux[0] = level_i;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= '0;
      en_q       <= '0;
      cfg_q      <= '0;
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      status_q   <= status_n;
      rd_valid_o <= rd_en_i;
      irq_o      <= |(status_q & en_q);
      if (rd_en_i) rdata_o <= rd_mux;
      if (wr_en_i) begin
        if (addr_i == ADDR_W'(A_EN)) en_q <= wdata_i[NUM_SRC-1:0];
        if (addr_i == ADDR_W'(A_FILT)) begin
          cfg_q.psc <= wdata_i[PSC_LSB +: PSC_W];
          cfg_q.thr <= wdata_i[THR_LSB +: THR_W];
        end
      end
    end
  end

  assign cfg_o = cfg_q;

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0));
  // R5
  rise_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rise_i) |-> status_q[ST_RISE]);
  // R6
  core_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $past(core_irq_i) |-> status_q[ST_CORE]);
  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) == '0) |-> !irq_o);
  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en_i) |-> rd_valid_o);
endmodule

// File: rtl/hpd_irq_top.sv
module hpd_irq_top
  import hpd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hpd_i,
  input  logic              core_irq_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o,
  output logic              irq_o,
  output logic              hpd_level_o
);
  logic      hpd_sync;
  logic      rise, fall, level;
  filt_cfg_t cfg;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(hpd_i), .q_o(hpd_sync)
  );

  hpd_debounce u_deb (
    .clk(clk), .rst(rst), .sample_i(hpd_sync), .cfg_i(cfg),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  hpd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .core_irq_i(core_irq_i),
    .rise_i(rise), .fall_i(fall), .level_i(level),
    .rdata_o(rdata_o), .rd_valid_o(rd_valid_o), .irq_o(irq_o), .cfg_o(cfg)
  );

  assign hpd_level_o = level;
endmodule

// File: tb/hpd_irq_top_tb_top.sv
module hpd_irq_top_tb_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hpd_i = 1'b0, core_irq_i = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic rd_valid_o, irq_o, hpd_level_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct { logic [DATA_W-1:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  hpd_irq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .hpd_i(hpd_i), .core_irq_i(core_irq_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rd_valid_o(rd_valid_o), .irq_o(irq_o),
    .hpd_level_o(hpd_level_o)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the design presents it
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (sb_q.size() == 0) check("R11 unexpected read", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rdata_o, e.val);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = ADDR_W'(a); wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DATA_W-1:0] exp, input string tag);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = ADDR_W'(a);
    sb_q.push_back('{val: exp, tag: tag});
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", irq_o, 0);
    check("R1 level after reset", hpd_level_o, 0);
    rd(0, 0, "R1 filter reset");
    rd(1, 0, "R1 status reset");
    rd(3, 0, "R1 enable reset");
    rd(4, 0, "R9 level reg reset");
    rd(2, 0, "R7 clear reads zero");
    rd(7, 0, "R11 unmapped reads zero");

    // R2 latency with filter at 0
    @(negedge clk); hpd_i = 1'b1;
    cyc(2); check("R2 level before third edge", hpd_level_o, 0);
    cyc(1); check("R2 level at third edge", hpd_level_o, 1);
    cyc(2);
    rd(1, 32'h2, "R5 rise sets bit1 while masked");
    check("R8 irq low while disabled", irq_o, 0);
    rd(4, 32'h1, "R9 level reads one");

    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'h7, "R8 enable width");
    cyc(1);
    check("R8 irq high when enabled", irq_o, 1);

    wr(2, 32'h0);
    rd(1, 32'h2, "R7 zero write keeps status");
    wr(2, 32'h2);
    cyc(2);
    rd(1, 32'h0, "R7 one clears rise");
    check("R8 irq drops after clear", irq_o, 0);

    // R5 fall
    @(negedge clk); hpd_i = 1'b0;
    cyc(6);
    rd(1, 32'h4, "R5 fall sets bit2");
    rd(4, 32'h0, "R9 level reads zero");
    check("R8 irq on fall", irq_o, 1);

    // R6 core interrupt sticky
    @(negedge clk); core_irq_i = 1'b1;
    @(negedge clk); core_irq_i = 1'b0;
    cyc(2);
    rd(1, 32'h5, "R6 core bit sticky");
    // set beats clear
    @(negedge clk); core_irq_i = 1'b1;
    wr(2, 32'h7);
    @(negedge clk); core_irq_i = 1'b0;
    cyc(1);
    rd(1, 32'h1, "R7 set beats clear");
    wr(2, 32'h1);
    cyc(1);
    rd(1, 32'h0, "R7 status cleared");

    // R10 filter layout
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0000_F0FF, "R10 filter field layout");

    // R3 threshold 4, no prescale
    wr(0, 32'h0000_0004);
    cyc(4);
    @(negedge clk); hpd_i = 1'b1;
    cyc(3); hpd_i = 1'b0;
    cyc(10);
    check("R3 short pulse rejected", hpd_level_o, 0);
    rd(1, 32'h0, "R3 no event from glitch");
    @(negedge clk); hpd_i = 1'b1;
    cyc(5); check("R3 level held before count", hpd_level_o, 0);
    cyc(1); check("R3 level after four samples", hpd_level_o, 1);
    @(negedge clk); hpd_i = 1'b0;
    cyc(12);
    wr(2, 32'h7);

    // R4 prescale 2^2 with threshold 4
    wr(0, 32'h0000_2004);
    cyc(4);
    @(negedge clk); hpd_i = 1'b1;
    cyc(10); hpd_i = 1'b0;
    cyc(30);
    check("R4 ten cycle pulse rejected", hpd_level_o, 0);
    @(negedge clk); hpd_i = 1'b1;
    cyc(14); check("R4 level held through twelve cycles", hpd_level_o, 0);
    cyc(4);  check("R4 level after prescaled samples", hpd_level_o, 1);
    cyc(2);
    rd(1, 32'h2, "R4 rise event after prescaled filter");

    cyc(4);
    while (sb_q.size() != 0) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule